// File: doc/BRIEF.md
# Scaled-Index Effective Address Unit

This unit forms the effective address of a memory operand from register contents and an immediate displacement. It owns a small file of eight general registers, each loaded through a dedicated write port. A request names a base register and an index register through 3-bit selectors, gives a 2-bit scale code, a displacement with a size flag, an address-size flag and a 2-bit mode. The unit reads the selected registers, scales the index, sign-extends the displacement and adds the terms the mode calls for.

The result is registered and appears one clock after the request together with a one-cycle valid strobe. Under 32-bit addressing the index may be multiplied by 1, 2, 4 or 8 and the displacement is 8 or 32 bits. Under 16-bit addressing the index is never scaled, the displacement is 8 or 16 bits, and the sum wraps within 16 bits. The unit is meant to sit between an operand decoder and a load/store path. It issues no memory access itself.

Top module: `eaddr_unit`

## Requirements
- R1: Mode code 0 (based) yields base register plus sign-extended displacement; the index register has no effect.
- R2: Mode code 1 (indexed) yields the scaled index register plus sign-extended displacement; the base register has no effect.
- R3: Mode code 2 (scaled based-indexed) yields base plus scaled index plus sign-extended displacement.
- R4: Mode code 3 (plain based-indexed) yields base plus index plus displacement, and the scale code has no effect.
- R5: With 32-bit addressing, scale codes 0, 1, 2 and 3 multiply the index by 1, 2, 4 and 8.
- R6: When the size flag is 0, only displacement bits 7:0 are used, sign-extended from bit 7. When it is 1, all 32 bits are used under 32-bit addressing, and bits 15:0 sign-extended from bit 15 under 16-bit addressing. Unused displacement bits have no effect.
- R7: With 16-bit addressing the scale code has no effect, the sum wraps modulo 2^16, and output bits 31:16 are zero.
- R8: With 32-bit addressing the sum wraps modulo 2^32.
- R9: A request sampled at a clock edge produces the address and a one-cycle valid strobe after that edge. Without a request the valid strobe is low and the address output keeps its last value.
- R10: A register write is visible to requests from the following cycle on. A request in the same cycle as a write to a register it reads sees the old contents.
- R11: After reset the valid strobe and the address output are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_mode | input | 2 | Addressing mode code (0 based, 1 indexed, 2 scaled based-indexed, 3 plain based-indexed) |
| req_base_sel | input | 3 | Base register selector |
| req_index_sel | input | 3 | Index register selector |
| req_scale | input | 2 | Scale code, shift of 0 to 3 bits |
| req_disp | input | 32 | Displacement value |
| req_disp_wide | input | 1 | 1: 32- or 16-bit displacement, 0: 8-bit |
| req_addr32 | input | 1 | 1: 32-bit addressing, 0: 16-bit |
| wr_en | input | 1 | Register write enable |
| wr_sel | input | 3 | Register write selector |
| wr_data | input | 32 | Register write data |
| ea_valid | output | 1 | Effective address valid strobe |
| ea_addr | output | 32 | Effective address |

## Verification
Each address is due exactly one cycle after its request edge, and the valid strobe rises in that same cycle. The driver stamps every expected item with the cycle count at the edge that captures the request. The monitor samples on the falling edge, pops an item only when the strobe is high, and compares both the address and the stamp with the current count, so a late, early or missing result shows up as a failure. In idle cycles the monitor checks that the strobe stays low and the address holds. The register model in the bench is updated only after the expected value of a same-cycle request has been formed, which pins down the one-cycle write visibility.

// File: rtl/eaddr_pkg.sv
package eaddr_pkg;
  localparam int ADDR_W  = 32;
  localparam int NARROW_W = 16;
  localparam int SHORT_W = 8;
  localparam int NREGS   = 8;
  localparam int SEL_W   = $clog2(NREGS);
  localparam int SCALE_W = 2;

  typedef enum logic [1:0] {
    EA_BASED      = 2'd0,
    EA_INDEXED    = 2'd1,
    EA_BIX_SCALED = 2'd2,
    EA_BIX_PLAIN  = 2'd3
  } ea_mode_e;
endpackage

// File: rtl/eaddr_regfile.sv
module eaddr_regfile #(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int SW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [SW-1:0] wsel,
  input  logic [DW-1:0] wdata,
  input  logic [SW-1:0] rsel_a,
  input  logic [SW-1:0] rsel_b,
  output logic [DW-1:0] rdata_a,
  output logic [DW-1:0] rdata_b
);
  logic [DW-1:0] store [DEPTH];

  // Write-only process, no reset, so the array maps to distributed RAM.
  always_ff @(posedge clk) begin
    if (we) store[wsel] <= wdata;
  end

  // Asynchronous reads: a write this cycle lands after the edge.
  assign rdata_a = store[rsel_a];
  assign rdata_b = store[rsel_b];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    we |=> store[$past(wsel)] == $past(wdata)); // R10
endmodule

// File: rtl/eaddr_disp_ext.sv
module eaddr_disp_ext #(
  parameter int DW  = 32,
  parameter int SW  = 8,
  parameter int MW  = 16
) (
  input  logic [DW-1:0] disp_i,
  input  logic          wide_i,
  input  logic          a32_i,
  output logic [DW-1:0] ext_o
);
  logic [DW-1:0] short_ext;
  logic [DW-1:0] mid_ext;

  assign short_ext = {{(DW-SW){disp_i[SW-1]}}, disp_i[SW-1:0]};
  assign mid_ext   = {{(DW-MW){disp_i[MW-1]}}, disp_i[MW-1:0]};

  always_comb begin
    if (!wide_i)     ext_o = short_ext;
    else if (a32_i)  ext_o = disp_i;
    else             ext_o = mid_ext;
  end

  always_comb begin
    AST_SHORT_SIGN: assert (wide_i || ext_o[DW-1:SW] == {(DW-SW){ext_o[SW-1]}}); // R6
  end
endmodule

// File: rtl/eaddr_scaler.sv
module eaddr_scaler #(
  parameter int DW = 32,
  parameter int CW = 2
) (
  input  logic [DW-1:0] idx_i,
  input  logic [CW-1:0] code_i,
  input  logic          a32_i,
  input  logic          plain_i,
  output logic [DW-1:0] scaled_o
);
  localparam int NFACT = 1 << CW;

  logic [DW-1:0] shifted [NFACT];
  logic [CW-1:0] eff_code;

  genvar g;
  generate
    for (g = 0; g < NFACT; g++) begin : g_shift
      assign shifted[g] = idx_i << g;
    end
  endgenerate

  // Scaling only applies to 32-bit addressing and the scaled modes.
  assign eff_code = (a32_i && !plain_i) ? code_i : '0;
  assign scaled_o = shifted[eff_code];
endmodule

// File: rtl/eaddr_unit.sv
module eaddr_unit
  import eaddr_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic [1:0]          req_mode,
  input  logic [SEL_W-1:0]    req_base_sel,
  input  logic [SEL_W-1:0]    req_index_sel,
  input  logic [SCALE_W-1:0]  req_scale,
  input  logic [ADDR_W-1:0]   req_disp,
  input  logic                req_disp_wide,
  input  logic                req_addr32,
  input  logic                wr_en,
  input  logic [SEL_W-1:0]    wr_sel,
  input  logic [ADDR_W-1:0]   wr_data,
  output logic                ea_valid,
  output logic [ADDR_W-1:0]   ea_addr
);
  ea_mode_e          mode;
  logic [ADDR_W-1:0] base_rd, idx_rd;
  logic [ADDR_W-1:0] disp_ext, idx_scaled;
  logic [ADDR_W-1:0] base_term, idx_term;
  logic [ADDR_W-1:0] raw_sum, sum_fit;

  assign mode = ea_mode_e'(req_mode);

  eaddr_regfile #(.DW(ADDR_W), .DEPTH(NREGS)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .we      (wr_en),
    .wsel    (wr_sel),
    .wdata   (wr_data),
    .rsel_a  (req_base_sel),
    .rsel_b  (req_index_sel),
    .rdata_a (base_rd),
    .rdata_b (idx_rd)
  );

  eaddr_disp_ext #(.DW(ADDR_W), .SW(SHORT_W), .MW(NARROW_W)) u_disp (
    .disp_i (req_disp),
    .wide_i (req_disp_wide),
    .a32_i  (req_addr32),
    .ext_o  (disp_ext)
  );

  eaddr_scaler #(.DW(ADDR_W), .CW(SCALE_W)) u_scale (
    .idx_i    (idx_rd),
    .code_i   (req_scale),
    .a32_i    (req_addr32),
    .plain_i  (mode == EA_BIX_PLAIN),
    .scaled_o (idx_scaled)
  );

  assign base_term = (mode == EA_INDEXED) ? '0 : base_rd;
  assign idx_term  = (mode == EA_BASED)   ? '0 : idx_scaled;
  assign raw_sum   = base_term + idx_term + disp_ext;
  assign sum_fit   = req_addr32 ? raw_sum
                                : {{(ADDR_W-NARROW_W){1'b0}}, raw_sum[NARROW_W-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      ea_valid <= 1'b0;
      ea_addr  <= '0;
    end else begin
      ea_valid <= req_valid;
      if (req_valid) ea_addr <= sum_fit;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    ea_valid |-> $past(req_valid)); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ea_valid && !$past(rst)) |-> $stable(ea_addr)); // R9

  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (ea_valid && !$past(req_addr32)) |-> ea_addr[ADDR_W-1:NARROW_W] == '0); // R7

  AST_NARROW_UNSCALED: assert property (@(posedge clk) disable iff (rst)
    !req_addr32 |-> idx_scaled == idx_rd); // R7
endmodule

// File: tb/eaddr_unit_bench.sv
module eaddr_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_mode = '0;
  logic [2:0]  req_base_sel = '0;
  logic [2:0]  req_index_sel = '0;
  logic [1:0]  req_scale = '0;
  logic [31:0] req_disp = '0;
  logic        req_disp_wide = 1'b0;
  logic        req_addr32 = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic        ea_valid;
  logic [31:0] ea_addr;

  eaddr_unit u_eaddr_unit (.*);

  always #4 clk = ~clk;

  typedef struct {
    logic [31:0] addr;
    int          due;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  logic [31:0] model [8];
  int          cyc = 0;
  int          total = 0;
  int          fails = 0;
  logic [31:0] last_addr = '0;
  bit          running = 1'b0;
  bit          done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] ref_ea(input logic [1:0] m, input logic [2:0] b,
      input logic [2:0] i, input logic [1:0] sc, input logic [31:0] d,
      input logic wide, input logic a32);
    logic [31:0] dx, ix, s;
    if (!wide)     dx = {{24{d[7]}}, d[7:0]};
    else if (a32)  dx = d;
    else           dx = {{16{d[15]}}, d[15:0]};
    ix = (a32 && m == 2'd1) || (a32 && m == 2'd2) ? (model[i] << sc) : model[i];
    case (m)
      2'd0:    s = model[b] + dx;
      2'd1:    s = ix + dx;
      default: s = model[b] + ix + dx;
    endcase
    if (!a32) s = {16'h0, s[15:0]};
    return s;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      req_valid = 1'b0;
      wr_en = 1'b0;
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] v);
    @(negedge clk);
    req_valid = 1'b0;
    wr_en = 1'b1; wr_sel = s; wr_data = v;
    model[s] = v;
  endtask

  // Drives one request; an optional write goes out in the same cycle.
  task automatic req(input string tag, input logic [1:0] m, input logic [2:0] b,
      input logic [2:0] i, input logic [1:0] sc, input logic [31:0] d,
      input logic wide, input logic a32,
      input logic we, input logic [2:0] ws, input logic [31:0] wv);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; req_mode = m; req_base_sel = b; req_index_sel = i;
    req_scale = sc; req_disp = d; req_disp_wide = wide; req_addr32 = a32;
    wr_en = we; wr_sel = ws; wr_data = wv;
    e.addr = ref_ea(m, b, i, sc, d, wide, a32);
    e.due  = cyc + 1;
    e.tag  = tag;
    sb.push_back(e);
    if (we) model[ws] = wv;
  endtask

  // Monitor: pops on every strobe, checks hold in idle cycles.
  always @(negedge clk) begin
    if (running) begin
      if (ea_valid) begin
        if (sb.size() == 0) begin
          total++; fails++;
          $display("FAIL R9: actual strobe with %h expected no result", ea_addr);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(e.tag, ea_addr, e.addr);
          check({e.tag, " latency"}, 32'(cyc), 32'(e.due));
          last_addr = ea_addr;
        end
      end else begin
        check("R9 idle hold", ea_addr, last_addr);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 8; k++) model[k] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R11 reset valid", {31'h0, ea_valid}, 32'h0);
    check("R11 reset addr", ea_addr, 32'h0);
    running = 1'b1;

    wr(3'd0, 32'h0000_1000);
    wr(3'd1, 32'h0000_0010);
    wr(3'd2, 32'h1234_5678);
    wr(3'd3, 32'hFFFF_FFF0);
    wr(3'd4, 32'h0001_FFF0);
    wr(3'd5, 32'h8000_0000);
    wr(3'd6, 32'h0000_0003);
    wr(3'd7, 32'h0000_0100);
    idle(2);

    // R1 based, positive and negative short displacement, garbage upper bits (R6)
    req("R1 based +disp", 2'd0, 3'd0, 3'd5, 2'd3, 32'h0000_0022, 1'b0, 1'b1, 1'b0, 3'd0, 32'h0);
    req("R1 based -disp", 2'd0, 3'd0, 3'd2, 2'd0, 32'h0000_0080, 1'b0, 1'b1, 1'b0, 3'd0, 32'h0);
    req("R6 short ignores upper", 2'd0, 3'd7, 3'd0, 2'd0, 32'hABCD_EF7F, 1'b0, 1'b1, 1'b0, 3'd0, 32'h0);
    idle(1);
    // R2 / R5 indexed with every scale code
    for (int s = 0; s < 4; s++)
      req("R5 indexed scale", 2'd1, 3'd2, 3'd6, 2'(s), 32'h0000_00F0, 1'b0, 1'b1, 1'b0, 3'd0, 32'h0);
    req("R2 indexed base ignored", 2'd1, 3'd5, 3'd1, 2'd2, 32'h0, 1'b0, 1'b1, 1'b0, 3'd0, 32'h0);
    idle(2);
    // R3 scaled based-indexed, R4 plain with scale code ignored
    req("R3 base+idx*8+disp", 2'd2, 3'd0, 3'd1, 2'd3, 32'h0000_0004, 1'b0, 1'b1, 1'b0, 3'd0, 32'h0);
    req("R3 base+idx*2 -disp", 2'd2, 3'd2, 3'd6, 2'd1, 32'h0000_00FE, 1'b0, 1'b1, 1'b0, 3'd0, 32'h0);
    req("R4 plain scale ignored", 2'd3, 3'd0, 3'd1, 2'd3, 32'h0000_0001, 1'b0, 1'b1, 1'b0, 3'd0, 32'h0);
    // R6 wide displacement, 32-bit and 16-bit addressing
    req("R6 wide32 disp", 2'd0, 3'd0, 3'd0, 2'd0, 32'h8765_4321, 1'b1, 1'b1, 1'b0, 3'd0, 32'h0);
    req("R6 wide16 disp sext", 2'd0, 3'd0, 3'd0, 2'd0, 32'h1234_8000, 1'b1, 1'b0, 1'b0, 3'd0, 32'h0);
    idle(3);
    // R7 narrow: wrap, upper zero, scale ignored
    req("R7 narrow wrap", 2'd0, 3'd4, 3'd0, 2'd0, 32'h0000_0020, 1'b0, 1'b0, 1'b0, 3'd0, 32'h0);
    req("R7 narrow scale ignored", 2'd2, 3'd7, 3'd6, 2'd3, 32'h0000_0005, 1'b0, 1'b0, 1'b0, 3'd0, 32'h0);
    req("R7 narrow upper zero", 2'd1, 3'd0, 3'd5, 2'd1, 32'h0000_7FFF, 1'b1, 1'b0, 1'b0, 3'd0, 32'h0);
    // R8 wide wrap
    req("R8 wrap 32", 2'd2, 3'd3, 3'd1, 2'd1, 32'h0000_0000, 1'b0, 1'b1, 1'b0, 3'd0, 32'h0);
    idle(2);
    // R10 write in same cycle not visible, then visible
    req("R10 same-cycle old", 2'd0, 3'd1, 3'd0, 2'd0, 32'h0, 1'b0, 1'b1, 1'b1, 3'd1, 32'h0000_5550);
    req("R10 next-cycle new", 2'd0, 3'd1, 3'd0, 2'd0, 32'h0, 1'b0, 1'b1, 1'b0, 3'd0, 32'h0);
    req("R10 same-cycle index old", 2'd1, 3'd0, 3'd6, 2'd2, 32'h0, 1'b0, 1'b1, 1'b1, 3'd6, 32'h0000_0009);
    req("R10 index new", 2'd1, 3'd0, 3'd6, 2'd2, 32'h0, 1'b0, 1'b1, 1'b0, 3'd0, 32'h0);
    idle(4);

    total++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R9: actual %0d pending results expected 0", sb.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule